// File: doc/BRIEF.md
# Watermark Memory Access Firewall

This block sits between the bus masters and one memory and judges every access in the cycle it is presented. The memory is cut into five stacked regions by four programmable page boundaries: a hide-protected secure privileged region at the top, then a secure privileged region, a non-secure privileged region, a non-secure unprivileged read-only region, and a non-secure unprivileged region that starts at page zero. The region an address falls in, together with the master (CPU1, CPU2 or a DMA channel), its secure, privileged and hide-mode attributes and the operation (read, write or instruction fetch), selects one entry of a fixed rights matrix.

A granted access is passed on, and only a granted write raises the memory write enable. A refused access returns a single-cycle error response on the following cycle and sets a sticky violation flag. Software clears the flag by writing one to it. The boundaries, the hide lock and the flag clear are reached through a small write-only register port. Only secure privileged CPU2 may use that port. Any other writer is ignored and raises the flag.

Top module: `fw_firewall`

## Requirements
- R1: The access page is `acc_addr >> PAGE_SHIFT`. Region is chosen by priority: page >= hide start gives the hide region, else page >= secure start gives secure, else page >= unprivileged watermark gives non-secure privileged, else page >= unprivileged write watermark gives read-only, else unprivileged. Each lower bound is inclusive. Operation code 3 and master code 3 are always refused. Operations are encoded 0 read, 1 write, 2 fetch. Masters are encoded 0 CPU1, 1 CPU2, 2 DMA.
- R2: When the unprivileged write watermark is at or above the unprivileged watermark, no read-only region exists. Every page below the unprivileged watermark then accepts unprivileged writes.
- R3: The secure region grants any operation only to a privileged CPU2 or DMA access with the secure attribute set. CPU1 and non-secure accesses are refused there.
- R4: In non-secure regions, CPU1 and DMA (secure or not) get read, write and fetch, within the privilege rules of R8.
- R5: CPU2 may read and write non-secure regions, but every CPU2 fetch from them is refused.
- R6: In the hide region, a secure privileged CPU2 access with hide mode set is granted any operation. CPU2 without hide mode, CPU1 and non-secure masters are refused.
- R7: While the hide lock is clear, a secure privileged DMA access to the hide region is granted read and write but not fetch. Once the lock is set, such accesses are refused.
- R8: Unprivileged accesses are refused in the hide, secure and non-secure privileged regions. In the read-only region they may read and fetch but not write. Privileged accesses may write there.
- R9: The hide lock (select 4, data bit 0) can only be set. Writing 0 leaves it set until reset.
- R10: A valid refused access drives `err_resp` high for exactly the next cycle. A refused write never raises `mem_wr_en`, and a granted write raises it in the same cycle.
- R11: `viol_flag` sets on a refused access or a rejected register write. It holds until an authorised write with data bit 0 set to select 5. Writing 0 to select 5 leaves it set.
- R12: Register writes (select 0 hide start, 1 secure start, 2 unprivileged watermark, 3 unprivileged write watermark) take effect only from CPU2 with both secure and privileged set. Any other write changes nothing and sets `viol_flag`.
- R13: After reset, all four boundaries equal the page count, so the whole memory is non-secure unprivileged. The lock, `err_resp` and `viol_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Byte offset from the memory base |
| acc_op | input | 2 | 0 read, 1 write, 2 fetch |
| acc_master | input | 2 | 0 CPU1, 1 CPU2, 2 DMA |
| acc_secure | input | 1 | Secure attribute |
| acc_priv | input | 1 | Privileged attribute |
| acc_hide_mode | input | 1 | CPU2 hide-protection mode |
| acc_allow | output | 1 | Access granted (combinational) |
| mem_wr_en | output | 1 | Write enable to the memory |
| err_resp | output | 1 | Error response, one cycle after a refusal |
| viol_flag | output | 1 | Sticky violation flag |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W-PAGE_SHIFT+1 | Write data (page boundary or control bit 0) |
| cfg_master | input | 2 | Master issuing the register write |
| cfg_secure | input | 1 | Secure attribute of the register write |
| cfg_priv | input | 1 | Privileged attribute of the register write |

## Verification
The assertions check, on every cycle, the properties that hold whatever the boundaries are. CPU1 never reaches a secure or hide page, and CPU2 never fetches from a non-secure page. Once locked, the hide region opens only to hide-mode CPU2. Unprivileged grants land only in the two unprivileged regions. A refusal always yields the error pulse and the flag, the flag and the lock never drop on their own, and rejected register writes leave the boundaries untouched. Only the bench's directed scenarios show that the boundaries decode at the right page edges. They also show that the read-only region vanishes when its watermarks cross, and that the matrix grants each legal access rather than merely refusing illegal ones.

// File: rtl/fw_pkg.sv
package fw_pkg;

    // operation codes
    localparam logic [1:0] OP_RD  = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_EX  = 2'd2;
    localparam logic [1:0] OP_RSV = 2'd3;

    // master codes
    localparam logic [1:0] MS_CPU1 = 2'd0;
    localparam logic [1:0] MS_CPU2 = 2'd1;
    localparam logic [1:0] MS_DMA  = 2'd2;
    localparam logic [1:0] MS_RSV  = 2'd3;

    // register selects
    localparam logic [2:0] CS_HIDE_START = 3'd0;
    localparam logic [2:0] CS_SEC_START  = 3'd1;
    localparam logic [2:0] CS_UWM        = 3'd2;
    localparam logic [2:0] CS_UWWM       = 3'd3;
    localparam logic [2:0] CS_LOCK       = 3'd4;
    localparam logic [2:0] CS_CLR        = 3'd5;

    // number of page boundaries, index 0 lowest
    localparam int unsigned NUM_BND = 4;

    typedef enum logic [2:0] {
        RG_UNPRIV = 3'd0,
        RG_URO    = 3'd1,
        RG_NSPRIV = 3'd2,
        RG_SEC    = 3'd3,
        RG_HIDE   = 3'd4
    } region_e;

endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs
    import fw_pkg::*;
#(
    parameter int unsigned WM_W = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [2:0]                     cfg_sel,
    input  logic [WM_W-1:0]                cfg_wdata,
    input  logic [1:0]                     cfg_master,
    input  logic                           cfg_secure,
    input  logic                           cfg_priv,
    output logic [NUM_BND-1:0][WM_W-1:0]   bnd,
    output logic                           hide_lock,
    output logic                           clr_pulse,
    output logic                           bad_wr
);

    localparam logic [WM_W-1:0] TOP_PAGE = {1'b1, {(WM_W-1){1'b0}}};

    typedef struct packed {
        logic [WM_W-1:0] hide_start;
        logic [WM_W-1:0] sec_start;
        logic [WM_W-1:0] uwm;
        logic [WM_W-1:0] uwwm;
        logic            lock;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       auth;
    logic       clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = 1'b0;
        auth  = cfg_wr && (cfg_master == MS_CPU2) && cfg_secure && cfg_priv;
        if (auth) begin
            case (cfg_sel)
                CS_HIDE_START: st_d.hide_start = cfg_wdata;
                CS_SEC_START:  st_d.sec_start  = cfg_wdata;
                CS_UWM:        st_d.uwm        = cfg_wdata;
                CS_UWWM:       st_d.uwwm       = cfg_wdata;
                CS_LOCK:       st_d.lock       = st_q.lock | cfg_wdata[0];
                CS_CLR:        clr_d           = cfg_wdata[0];
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hide_start <= TOP_PAGE;
            st_q.sec_start  <= TOP_PAGE;
            st_q.uwm        <= TOP_PAGE;
            st_q.uwwm       <= TOP_PAGE;
            st_q.lock       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd[0]    = st_q.uwwm;
    assign bnd[1]    = st_q.uwm;
    assign bnd[2]    = st_q.sec_start;
    assign bnd[3]    = st_q.hide_start;
    assign hide_lock = st_q.lock;
    assign clr_pulse = clr_d;
    assign bad_wr    = cfg_wr && !auth;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R9

    AST_REJECTED_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !(cfg_master == MS_CPU2 && cfg_secure && cfg_priv))
        |=> ($stable(st_q.hide_start) && $stable(st_q.sec_start)
             && $stable(st_q.uwm) && $stable(st_q.uwwm) && $stable(st_q.lock))); // R12

endmodule

// File: rtl/fw_region_decode.sv
module fw_region_decode
    import fw_pkg::*;
#(
    parameter int unsigned PG_W = 8,
    parameter int unsigned WM_W = PG_W + 1
) (
    input  logic [PG_W-1:0]                page,
    input  logic [NUM_BND-1:0][WM_W-1:0]   bnd,
    output region_e                        region
);

    logic [NUM_BND-1:0] at_or_above;
    logic [WM_W-1:0]    page_ext;

    assign page_ext = {1'b0, page};

    for (genvar g = 0; g < NUM_BND; g++) begin : g_cmp
        assign at_or_above[g] = (page_ext >= bnd[g]);
    end

    always_comb begin
        if (at_or_above[3])      region = RG_HIDE;
        else if (at_or_above[2]) region = RG_SEC;
        else if (at_or_above[1]) region = RG_NSPRIV;
        else if (at_or_above[0]) region = RG_URO;
        else                     region = RG_UNPRIV;
    end

endmodule

// File: rtl/fw_rights.sv
module fw_rights
    import fw_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] op,
    input  logic [1:0] master,
    input  logic       secure,
    input  logic       priv,
    input  logic       hide_mode,
    input  logic       hide_lock,
    output logic       allow
);

    logic is_cpu2;
    logic sec_master;
    logic cpu2_fetch;
    logic hide_owner;
    logic dma_pre_lock;
    logic legal;
    logic grant;

    always_comb begin
        is_cpu2      = (master == MS_CPU2);
        sec_master   = (is_cpu2 || master == MS_DMA) && secure;
        cpu2_fetch   = is_cpu2 && (op == OP_EX);
        hide_owner   = is_cpu2 && secure && priv && hide_mode;
        dma_pre_lock = !hide_lock && (master == MS_DMA) && secure && priv
                       && (op != OP_EX);
        legal        = (op != OP_RSV) && (master != MS_RSV);

        case (region)
            RG_HIDE:   grant = hide_owner || dma_pre_lock;
            RG_SEC:    grant = sec_master && priv;
            RG_NSPRIV: grant = priv && !cpu2_fetch;
            RG_URO:    grant = (priv || op != OP_WR) && !cpu2_fetch;
            RG_UNPRIV: grant = !cpu2_fetch;
            default:   grant = 1'b0;
        endcase

        allow = legal && grant;
    end

endmodule

// File: rtl/fw_firewall.sv
module fw_firewall
    import fw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PAGE_SHIFT = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic [ADDR_W-1:0]                acc_addr,
    input  logic [1:0]                       acc_op,
    input  logic [1:0]                       acc_master,
    input  logic                             acc_secure,
    input  logic                             acc_priv,
    input  logic                             acc_hide_mode,
    output logic                             acc_allow,
    output logic                             mem_wr_en,
    output logic                             err_resp,
    output logic                             viol_flag,
    input  logic                             cfg_wr,
    input  logic [2:0]                       cfg_sel,
    input  logic [ADDR_W-PAGE_SHIFT:0]       cfg_wdata,
    input  logic [1:0]                       cfg_master,
    input  logic                             cfg_secure,
    input  logic                             cfg_priv
);

    localparam int unsigned PG_W = ADDR_W - PAGE_SHIFT;
    localparam int unsigned WM_W = PG_W + 1;

    typedef struct packed {
        logic err;
        logic viol;
    } top_state_t;

    top_state_t                   st_d, st_q;
    logic [NUM_BND-1:0][WM_W-1:0] bnd;
    logic                         hide_lock;
    logic                         clr_pulse;
    logic                         bad_wr;
    logic [PG_W-1:0]              page;
    region_e                      region;
    logic                         grant;
    logic                         refused;
    logic                         unused_low;

    assign page       = acc_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_low = ^acc_addr[PAGE_SHIFT-1:0];

    fw_cfg_regs #(.WM_W(WM_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_master (cfg_master),
        .cfg_secure (cfg_secure),
        .cfg_priv   (cfg_priv),
        .bnd        (bnd),
        .hide_lock  (hide_lock),
        .clr_pulse  (clr_pulse),
        .bad_wr     (bad_wr)
    );

    fw_region_decode #(.PG_W(PG_W), .WM_W(WM_W)) u_dec (
        .page   (page),
        .bnd    (bnd),
        .region (region)
    );

    fw_rights u_rights (
        .region    (region),
        .op        (acc_op),
        .master    (acc_master),
        .secure    (acc_secure),
        .priv      (acc_priv),
        .hide_mode (acc_hide_mode),
        .hide_lock (hide_lock),
        .allow     (grant)
    );

    always_comb begin
        refused   = acc_valid && !grant;
        st_d.err  = refused;
        st_d.viol = (st_q.viol && !clr_pulse) || refused || bad_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_allow = grant;
    assign mem_wr_en = acc_valid && grant && (acc_op == OP_WR);
    assign err_resp  = st_q.err;
    assign viol_flag = st_q.viol;

    AST_REFUSAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=> (err_resp && viol_flag)); // R10

    AST_VIOL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clr_pulse) |=> viol_flag); // R11

    AST_CPU1_NO_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_master == MS_CPU1 && (region == RG_SEC || region == RG_HIDE))
        |-> !acc_allow); // R3

    AST_CPU2_NO_NS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_master == MS_CPU2 && acc_op == OP_EX && acc_allow)
        |-> (region == RG_SEC || region == RG_HIDE)); // R5

    AST_LOCKED_HIDE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (hide_lock && region == RG_HIDE && acc_allow)
        |-> (acc_master == MS_CPU2 && acc_hide_mode)); // R7

    AST_UNPRIV_PLACEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_allow && !acc_priv)
        |-> (region == RG_UNPRIV || (region == RG_URO && acc_op != OP_WR))); // R8

endmodule

// File: tb/fw_firewall_tb_top.sv
`timescale 1ns/100ps
module fw_firewall_tb_top;

    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned PAGE_SHIFT = 8;
    localparam int unsigned WM_W       = ADDR_W - PAGE_SHIFT + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [1:0]        acc_op = '0;
    logic [1:0]        acc_master = '0;
    logic              acc_secure = 1'b0;
    logic              acc_priv = 1'b0;
    logic              acc_hide_mode = 1'b0;
    logic              acc_allow;
    logic              mem_wr_en;
    logic              err_resp;
    logic              viol_flag;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [WM_W-1:0]   cfg_wdata = '0;
    logic [1:0]        cfg_master = '0;
    logic              cfg_secure = 1'b0;
    logic              cfg_priv = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    fw_firewall #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_op(acc_op),
        .acc_master(acc_master), .acc_secure(acc_secure), .acc_priv(acc_priv),
        .acc_hide_mode(acc_hide_mode), .acc_allow(acc_allow),
        .mem_wr_en(mem_wr_en), .err_resp(err_resp), .viol_flag(viol_flag),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_master(cfg_master), .cfg_secure(cfg_secure), .cfg_priv(cfg_priv)
    );

    // codes
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
    localparam logic [1:0] C1 = 2'd0, C2 = 2'd1, DM = 2'd2;

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] pg(input int p);
        return ADDR_W'(p << PAGE_SHIFT) | ADDR_W'(8'h3C);
    endfunction

    // present an access and check the same-cycle decision
    task automatic probe(input string tag, input int p, input logic [1:0] op,
                         input logic [1:0] m, input logic s, input logic pr,
                         input logic hm, input logic exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = pg(p); acc_op = op; acc_master = m;
        acc_secure = s; acc_priv = pr; acc_hide_mode = hm;
        #1;
        check(tag, $sformatf("allow page %0d op %0d master %0d", p, op, m),
              acc_allow, exp);
        if (op == WR) check(tag, "mem_wr_en follows grant", mem_wr_en, exp);
    endtask

    task automatic cfg(input logic [2:0] sel, input int data, input logic [1:0] m,
                       input logic s, input logic pr);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = WM_W'(data);
        cfg_master = m; cfg_secure = s; cfg_priv = pr;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_ok(input logic [2:0] sel, input int data);
        cfg(sel, data, C2, 1'b1, 1'b1);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R13", "err_resp after reset", err_resp, 1'b0);
        check("R13", "viol_flag after reset", viol_flag, 1'b0);
        probe("R13", 255, WR, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R13", 0, RD, DM, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R5", 0, EX, C2, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R1", 3, 2'd3, C1, 1'b0, 1'b1, 1'b0, 1'b0);
        probe("R1", 3, RD, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_program();
        cfg_ok(3'd0, 200);
        cfg_ok(3'd1, 150);
        cfg_ok(3'd2, 100);
        cfg_ok(3'd3, 50);
    endtask

    task automatic t_regions();
        // R1 edges
        probe("R1", 149, EX, C1, 1'b0, 1'b1, 1'b0, 1'b1);
        probe("R1", 150, EX, C1, 1'b0, 1'b1, 1'b0, 1'b0);
        probe("R1", 49, WR, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R1", 50, WR, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R8 read-only and privileged regions
        probe("R8", 99, RD, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R8", 75, EX, DM, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R8", 100, RD, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R8", 160, RD, C2, 1'b1, 1'b0, 1'b0, 1'b0);
        // R3 secure region
        probe("R3", 160, RD, DM, 1'b0, 1'b1, 1'b0, 1'b0);
        probe("R3", 160, EX, C2, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R3", 199, WR, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R3", 170, WR, C2, 1'b0, 1'b1, 1'b0, 1'b0);
        // R4 non-secure grants
        probe("R4", 120, EX, DM, 1'b0, 1'b1, 1'b0, 1'b1);
        probe("R4", 10, WR, DM, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R4", 60, WR, C1, 1'b0, 1'b1, 1'b0, 1'b1);
        probe("R4", 130, WR, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        // R5 CPU2 on non-secure pages
        probe("R5", 120, RD, C2, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R5", 10, WR, C2, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R5", 10, EX, C2, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R5", 120, EX, C2, 1'b1, 1'b1, 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_no_ro();
        cfg_ok(3'd3, 120);
        probe("R2", 60, WR, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R2", 99, WR, DM, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R2", 100, RD, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R2", 110, RD, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_ok(3'd3, 100);
        probe("R2", 99, WR, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        probe("R2", 100, WR, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_ok(3'd3, 50);
        probe("R2", 60, WR, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_hide();
        probe("R6", 220, EX, C2, 1'b1, 1'b1, 1'b1, 1'b1);
        probe("R6", 220, RD, C2, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R6", 255, RD, C1, 1'b0, 1'b1, 1'b0, 1'b0);
        probe("R6", 200, RD, DM, 1'b0, 1'b1, 1'b0, 1'b0);
        probe("R7", 200, RD, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R7", 210, WR, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R7", 210, EX, DM, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R7", 200, RD, DM, 1'b1, 1'b0, 1'b0, 1'b0);
        probe("R1", 199, EX, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        cfg_ok(3'd4, 1);
        probe("R7", 200, RD, DM, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R7", 230, WR, DM, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R6", 200, WR, C2, 1'b1, 1'b1, 1'b1, 1'b1);
        probe("R6", 240, RD, C2, 1'b1, 1'b1, 1'b0, 1'b0);
        cfg_ok(3'd4, 0);
        probe("R9", 200, RD, DM, 1'b1, 1'b1, 1'b0, 1'b0);
        probe("R9", 199, RD, DM, 1'b1, 1'b1, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_err();
        cfg_ok(3'd5, 1);
        check("R11", "flag cleared by write-one", viol_flag, 1'b0);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = pg(160); acc_op = WR; acc_master = C1;
        acc_secure = 1'b0; acc_priv = 1'b0; acc_hide_mode = 1'b0;
        #1;
        check("R10", "refused write blocked", mem_wr_en, 1'b0);
        check("R10", "no error before edge", err_resp, 1'b0);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10", "error one cycle after refusal", err_resp, 1'b1);
        check("R11", "flag set by refusal", viol_flag, 1'b1);
        @(negedge clk);
        check("R10", "error lasts one cycle", err_resp, 1'b0);
        acc_valid = 1'b1; acc_addr = pg(10); acc_op = WR; acc_master = C1;
        #1;
        check("R10", "granted write enabled", mem_wr_en, 1'b1);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10", "no error after grant", err_resp, 1'b0);
    endtask

    task automatic t_viol();
        repeat (3) @(negedge clk);
        check("R11", "flag holds while idle", viol_flag, 1'b1);
        cfg_ok(3'd5, 0);
        check("R11", "write of zero keeps flag", viol_flag, 1'b1);
        cfg_ok(3'd5, 1);
        check("R11", "write of one clears flag", viol_flag, 1'b0);
        probe("R11", 20, RD, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        idle();
        check("R11", "grant leaves flag clear", viol_flag, 1'b0);
    endtask

    task automatic t_cfg_guard();
        cfg(3'd2, 0, C1, 1'b0, 1'b1);
        check("R12", "CPU1 write flags violation", viol_flag, 1'b1);
        probe("R12", 60, RD, C1, 1'b0, 1'b0, 1'b0, 1'b1);
        cfg(3'd5, 1, C1, 1'b1, 1'b1);
        check("R12", "unauthorised clear ignored", viol_flag, 1'b1);
        cfg_ok(3'd5, 1);
        cfg(3'd3, 120, C2, 1'b0, 1'b1);
        check("R12", "non-secure CPU2 write flags", viol_flag, 1'b1);
        probe("R12", 60, WR, C1, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_ok(3'd5, 1);
        cfg(3'd1, 0, C2, 1'b1, 1'b0);
        check("R12", "unprivileged CPU2 write flags", viol_flag, 1'b1);
        probe("R12", 120, RD, C1, 1'b0, 1'b1, 1'b0, 1'b1);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_regions();
        t_no_ro();
        t_hide();
        t_err();
        t_viol();
        t_cfg_guard();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule